// File: doc/BRIEF.md
# Data Register Byte Packing Buffer

This block sits behind the 16-bit data register of a two-wire serial bus controller. Software writes transmit data through it in 16-bit or 8-bit accesses. It reads received data back in 16-bit accesses. Internally the data lives in a small byte buffer, four lanes by default, with lane 0 as the lowest. Two separate counters track how many transmit bytes and how many receive bytes that buffer holds.

On the other side, the bus sequencer takes transmit bytes out one at a time and deposits received bytes one at a time. The block applies the selectable byte order on every 16-bit access. It also reports, as one-cycle pulses, the status side effects that a data-register access has on the controller: clearing the transmit flags and restarting the sequencer, clearing the receive flags, flagging an empty read, ending a master receive, and flagging a dropped access.

A bus access, whether a write or a read, takes precedence over a sequencer operation in the same cycle. A write takes precedence over a read.

Top module: `byte_pack_buf`

## Requirements
- R1: After reset, tx_cnt and rx_cnt are 0, tx_avail is 0, rd_data reads 0x0000, and every status pulse output is low.
- R2: An accepted 16-bit write shifts the held bytes up two lanes. It puts wr_data[15:8] in lane 1 and wr_data[7:0] in lane 0 when swap_en is 1, or wr_data[7:0] in lane 1 and wr_data[15:8] in lane 0 when swap_en is 0, and adds 2 to tx_cnt.
- R3: An accepted 8-bit write shifts the held bytes up one lane, puts wr_data[7:0] in lane 0, adds 1 to tx_cnt and marks the buffer as closed. While the buffer is closed, every further write is dropped and flagged on ovf. The buffer reopens when tx_cnt returns to 0.
- R4: While tx_cnt is nonzero, tx_byte shows lane tx_cnt-1, so bytes leave from the highest filled lane downward. A tx_pop subtracts 1 from tx_cnt. A tx_pop with tx_cnt at 0 has no effect.
- R5: An rx_push places rx_byte in lane rx_cnt and adds 1 to rx_cnt. An rx_push with rx_cnt equal to the lane count is dropped, leaves the buffer unchanged and pulses ovf.
- R6: rd_data is {lane1, lane0} when swap_en is 0 and {lane0, lane1} when swap_en is 1. A lane at or above rx_cnt reads as 0x00.
- R7: A read with rx_cnt of at least 2 removes two bytes, and a read with rx_cnt of 1 removes one. In both cases the remaining bytes shift down so that the oldest one sits in lane 0.
- R8: A read with rx_cnt at 0 pulses rd_empty in the next cycle and changes neither count.
- R9: Every read pulses rd_ack in the next cycle. rd_master_done also pulses when master_rx is 1 during the read.
- R10: An accepted write pulses wr_kick in the next cycle. A 16-bit write with more than lane-count-2 bytes held, or an 8-bit write with the buffer full, is dropped. A dropped write pulses ovf, does not pulse wr_kick and leaves the buffer unchanged.
- R11: A cycle with wr16, wr8 or rd high ignores tx_pop and rx_push. When a write and a read coincide, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | Byte-order select for 16-bit accesses |
| master_rx | input | 1 | Controller is bus master and receiving |
| wr16 | input | 1 | 16-bit data register write strobe |
| wr8 | input | 1 | 8-bit data register write strobe |
| wr_data | input | 16 | Write data |
| rd | input | 1 | Data register read strobe |
| rd_data | output | 16 | Read data, valid before the read strobe is taken |
| tx_pop | input | 1 | Sequencer takes one transmit byte |
| tx_byte | output | 8 | Next transmit byte |
| tx_avail | output | 1 | At least one transmit byte held |
| rx_push | input | 1 | Sequencer deposits one received byte |
| rx_byte | input | 8 | Received byte |
| tx_cnt | output | CW | Transmit bytes held |
| rx_cnt | output | CW | Receive bytes held |
| wr_kick | output | 1 | Pulse: clear transmit flags, restart sequencer |
| rd_ack | output | 1 | Pulse: clear receive-ready and receive-overrun |
| rd_empty | output | 1 | Pulse: read found the buffer empty |
| rd_master_done | output | 1 | Pulse: set access-ready, leave master mode |
| ovf | output | 1 | Pulse: a write or push was dropped |

## Verification
The hardest state to reach is the closed buffer after an 8-bit write. Reaching it needs a partial 16-bit fill followed by a byte write. Releasing it needs every byte popped in order. The bench builds that sequence, checks that a later 16-bit write is refused without disturbing the held bytes, and then drains the buffer to show that the buffer reopens. Mixed lane orders are reached through back-to-back 16-bit writes with opposite swap settings, followed by a drain. A read is also issued in the same cycle as a sequencer push and as a write, to expose the priority order.

// File: rtl/byte_pack_buf.sv
module byte_pack_buf #(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap_en,
  input  logic          master_rx,
  input  logic          wr16,
  input  logic          wr8,
  input  logic [15:0]   wr_data,
  input  logic          rd,
  output logic [15:0]   rd_data,
  input  logic          tx_pop,
  output logic [7:0]    tx_byte,
  output logic          tx_avail,
  input  logic          rx_push,
  input  logic [7:0]    rx_byte,
  output logic [CW-1:0] tx_cnt,
  output logic [CW-1:0] rx_cnt,
  output logic          wr_kick,
  output logic          rd_ack,
  output logic          rd_empty,
  output logic          rd_master_done,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL  = CW'(LANES);
  localparam logic [CW-1:0] FULL2 = CW'(LANES - 2);

  logic [8*LANES-1:0] buf_q;
  logic               closed;

  wire bus_wr   = wr16 | wr8;
  wire bus_rd   = rd & ~bus_wr;
  wire seq_ok   = ~(bus_wr | rd);
  wire wr_drop  = wr16 ? (closed || tx_cnt > FULL2) : (closed || tx_cnt == FULL);
  wire wr_ok    = bus_wr & ~wr_drop;
  wire pop_ok   = tx_pop & seq_ok & (tx_cnt != '0);
  wire push_any = rx_push & seq_ok;
  wire push_ok  = push_any & (rx_cnt != FULL);

  wire [7:0] hi_in = swap_en ? wr_data[15:8] : wr_data[7:0];
  wire [7:0] lo_in = swap_en ? wr_data[7:0]  : wr_data[15:8];
  wire [7:0] rl0   = (rx_cnt != '0)        ? buf_q[7:0]  : 8'h00;
  wire [7:0] rl1   = (rx_cnt > CW'(1))     ? buf_q[15:8] : 8'h00;

  assign rd_data  = swap_en ? {rl0, rl1} : {rl1, rl0};
  assign tx_avail = (tx_cnt != '0);

  always_comb begin
    tx_byte = 8'h00;
    for (int i = 0; i < LANES; i++)
      if (tx_cnt == CW'(i + 1)) tx_byte = buf_q[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q          <= '0;
      closed         <= 1'b0;
      tx_cnt         <= '0;
      rx_cnt         <= '0;
      wr_kick        <= 1'b0;
      rd_ack         <= 1'b0;
      rd_empty       <= 1'b0;
      rd_master_done <= 1'b0;
      ovf            <= 1'b0;
    end else begin
      wr_kick        <= wr_ok;
      rd_ack         <= bus_rd;
      rd_empty       <= bus_rd && rx_cnt == '0;
      rd_master_done <= bus_rd && master_rx;
      ovf            <= (bus_wr && wr_drop) || (push_any && !push_ok);
      if (wr_ok) begin
        if (wr16) begin
          buf_q  <= {buf_q[8*LANES-17:0], hi_in, lo_in};
          tx_cnt <= tx_cnt + CW'(2);
        end else begin
          buf_q  <= {buf_q[8*LANES-9:0], wr_data[7:0]};
          tx_cnt <= tx_cnt + CW'(1);
          closed <= 1'b1;
        end
      end else if (bus_rd) begin
        if (rx_cnt > CW'(1)) begin
          buf_q  <= buf_q >> 16;
          rx_cnt <= rx_cnt - CW'(2);
        end else if (rx_cnt == CW'(1)) begin
          buf_q  <= buf_q >> 8;
          rx_cnt <= '0;
        end
      end else if (pop_ok) begin
        tx_cnt <= tx_cnt - CW'(1);
        if (tx_cnt == CW'(1)) closed <= 1'b0;
      end else if (push_ok) begin
        for (int i = 0; i < LANES; i++)
          if (rx_cnt == CW'(i)) buf_q[8*i +: 8] <= rx_byte;
        rx_cnt <= rx_cnt + CW'(1);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL); // R5
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> tx_cnt == $past(tx_cnt) - CW'(1)); // R4
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rx_cnt == '0) |=> rd_empty && $stable(rx_cnt) && $stable(tx_cnt)); // R8
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16 && tx_cnt > FULL2) |=> ovf && !wr_kick && $stable(tx_cnt) && $stable(buf_q)); // R10
  AST_READ_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rx_cnt > CW'(1)) |=> rx_cnt == $past(rx_cnt) - CW'(2)); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_kick && rd_ack)); // R11
endmodule

// File: tb/byte_pack_buf_tb.sv
module byte_pack_buf_tb;
  localparam int CW = 3;
  logic clk = 0, rst_n = 0;
  logic swap_en = 0, master_rx = 0, wr16 = 0, wr8 = 0, rd = 0, tx_pop = 0, rx_push = 0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] rd_data;
  logic [7:0]  tx_byte;
  logic        tx_avail, wr_kick, rd_ack, rd_empty, rd_master_done, ovf;
  logic [CW-1:0] tx_cnt, rx_cnt;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  byte_pack_buf u_dut (.clk, .rst_n, .swap_en, .master_rx, .wr16, .wr8, .wr_data, .rd,
    .rd_data, .tx_pop, .tx_byte, .tx_avail, .rx_push, .rx_byte, .tx_cnt, .rx_cnt,
    .wr_kick, .rd_ack, .rd_empty, .rd_master_done, .ovf);

  // op: 0 wr16, 1 wr8, 2 pop, 3 push, 4 read; {op, swap, data, expected seen, exp tx, exp rx}
  localparam logic [41:0] VEC [22] = '{
    {3'd0,1'b0,16'h1122,16'h0000,3'd2,3'd0},
    {3'd2,1'b0,16'h0000,16'h0022,3'd1,3'd0},
    {3'd2,1'b0,16'h0000,16'h0011,3'd0,3'd0},
    {3'd0,1'b1,16'h3344,16'h0000,3'd2,3'd0},
    {3'd0,1'b0,16'h5566,16'h0000,3'd4,3'd0},
    {3'd2,1'b0,16'h0000,16'h0033,3'd3,3'd0},
    {3'd2,1'b0,16'h0000,16'h0044,3'd2,3'd0},
    {3'd2,1'b0,16'h0000,16'h0066,3'd1,3'd0},
    {3'd2,1'b0,16'h0000,16'h0055,3'd0,3'd0},
    {3'd3,1'b0,16'h00A1,16'h0000,3'd0,3'd1},
    {3'd3,1'b0,16'h00B2,16'h0000,3'd0,3'd2},
    {3'd3,1'b0,16'h00C3,16'h0000,3'd0,3'd3},
    {3'd4,1'b0,16'h0000,16'hB2A1,3'd0,3'd1},
    {3'd3,1'b0,16'h00D4,16'h0000,3'd0,3'd2},
    {3'd4,1'b1,16'h0000,16'hC3D4,3'd0,3'd0},
    {3'd3,1'b0,16'h00E5,16'h0000,3'd0,3'd1},
    {3'd4,1'b0,16'h0000,16'h00E5,3'd0,3'd0},
    {3'd0,1'b0,16'h7788,16'h0000,3'd2,3'd0},
    {3'd1,1'b0,16'h0099,16'h0000,3'd3,3'd0},
    {3'd2,1'b0,16'h0000,16'h0088,3'd2,3'd0},
    {3'd2,1'b0,16'h0000,16'h0077,3'd1,3'd0},
    {3'd2,1'b0,16'h0000,16'h0099,3'd0,3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic op(input int code, input logic [15:0] d, input logic sw, output logic [15:0] seen);
    swap_en = sw; wr_data = d; rx_byte = d[7:0];
    case (code)
      0: wr16 = 1;
      1: wr8 = 1;
      2: tx_pop = 1;
      3: rx_push = 1;
      default: rd = 1;
    endcase
    #1 seen = (code == 2) ? {8'h00, tx_byte} : rd_data;
    @(negedge clk);
    wr16 = 0; wr8 = 0; tx_pop = 0; rx_push = 0; rd = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s;
    string tg;
    repeat (3) @(negedge clk);
    chk("R1 tx_cnt", tx_cnt, 0);
    chk("R1 rx_cnt", rx_cnt, 0);
    chk("R1 tx_avail", tx_avail, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 pulses", {wr_kick, rd_ack, rd_empty, rd_master_done, ovf}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 22; i++) begin
      op(int'(VEC[i][41:39]), VEC[i][37:22], VEC[i][38], s);
      case (VEC[i][41:39])
        3'd0: tg = "R2";
        3'd1: tg = "R3";
        3'd2: tg = "R4";
        3'd3: tg = "R5";
        default: tg = "R6 R7";
      endcase
      if (VEC[i][41:39] == 3'd2 || VEC[i][41:39] == 3'd4)
        chk({tg, " data"}, s, VEC[i][21:6]);
      chk({tg, " tx_cnt"}, tx_cnt, VEC[i][5:3]);
      chk({tg, " rx_cnt"}, rx_cnt, VEC[i][2:0]);
    end

    // R8 R9: empty read with master receive
    master_rx = 1;
    op(4, 0, 0, s);
    chk("R8 rd_empty", rd_empty, 1);
    chk("R8 rx_cnt", rx_cnt, 0);
    chk("R9 rd_ack", rd_ack, 1);
    chk("R9 rd_master_done", rd_master_done, 1);
    master_rx = 0;
    op(3, 16'h0011, 0, s);
    op(4, 0, 0, s);
    chk("R9 no master_done", rd_master_done, 0);
    chk("R8 not empty", rd_empty, 0);

    // R4: pop on empty ignored
    op(2, 0, 0, s);
    chk("R4 empty pop", tx_cnt, 0);

    // R10: overflow write
    op(0, 16'h0102, 0, s);
    chk("R10 wr_kick", wr_kick, 1);
    op(0, 16'h0304, 0, s);
    op(0, 16'h0506, 0, s);
    chk("R10 ovf", ovf, 1);
    chk("R10 no kick", wr_kick, 0);
    chk("R10 tx_cnt", tx_cnt, 4);
    op(1, 16'h0007, 0, s);
    chk("R10 wr8 full ovf", ovf, 1);
    op(2, 0, 0, s);
    chk("R10 top byte kept", s, 16'h0002);
    repeat (3) op(2, 0, 0, s);
    chk("R10 drained", tx_cnt, 0);

    // R3: closed after byte write, reopens on drain
    op(0, 16'hAABB, 0, s);
    op(1, 16'h00CC, 0, s);
    op(0, 16'h1234, 0, s);
    chk("R3 closed ovf", ovf, 1);
    chk("R3 tx_cnt", tx_cnt, 3);
    op(2, 0, 0, s);
    chk("R3 order", s, 16'h00BB);
    op(2, 0, 0, s);
    op(2, 0, 0, s);
    chk("R3 last byte", s, 16'h00CC);
    op(0, 16'h5678, 0, s);
    chk("R3 reopened", {ovf, tx_cnt}, {1'b0, 3'd2});
    op(2, 0, 0, s);
    op(2, 0, 0, s);

    // R5: receive overflow
    for (int k = 0; k < 4; k++) op(3, 16'(k + 16'h40), 0, s);
    op(3, 16'h00FF, 0, s);
    chk("R5 push ovf", ovf, 1);
    chk("R5 rx_cnt", rx_cnt, 4);
    op(4, 0, 0, s);
    chk("R5 R6 first pair", s, 16'h4140);
    op(4, 0, 0, s);
    chk("R5 second pair", s, 16'h4342);

    // R11: read with push, write with pop, write with read
    op(3, 16'h0055, 0, s);
    rx_push = 1; rx_byte = 8'h66;
    op(4, 0, 0, s);
    chk("R11 push ignored", rx_cnt, 0);
    tx_pop = 1;
    op(0, 16'h1111, 0, s);
    chk("R11 pop ignored", tx_cnt, 2);
    rd = 1;
    op(0, 16'h2222, 0, s);
    chk("R11 write wins", {tx_cnt, rd_ack, wr_kick}, {3'd4, 1'b0, 1'b1});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule